// File: doc/BRIEF.md
# Systolic Edit Distance Array

This block measures how far apart two short sequences of 2-bit symbols are. The distance is the smallest number of single-symbol insertions, deletions and substitutions that turns the source sequence into the target sequence. Each of the three operations costs one unit. A caller loads both sequences and their lengths with a one-cycle start pulse. After a fixed number of cycles the block presents the distance together with a one-cycle done strobe.

Inside, a row of cells covers the anti-diagonals of the dynamic-programming table. Cell `c` owns diagonal `c - N`. Source symbols enter at the top end of the row and move one cell down per cycle. Target symbols enter at the bottom end and move one cell up per cycle. Symbols are injected only on even steps, so each stream carries an empty slot between symbols and every source/target pair lands in exactly one shared cell. When two symbols share a cell, that cell forms the new table entry from three values:
- its own value from two steps earlier (the diagonal predecessor);
- the value its lower neighbour formed one step earlier;
- the value its upper neighbour formed one step earlier.

Each cell loads its border value `|c - N|` on a step that depends on its position. Cells exchange data only with adjacent cells. Table entries are held in `DW` bits and saturate at all-ones.

Top module: `edit_dist_array`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `busy_o`, `done_o` and `dist_o` are all 0.
- R2: A high `start_i` sampled while `busy_o` is low captures both lengths and both sequences, and `busy_o` is high from the next cycle.
- R3: With both lengths at most N, the reported distance is the unit-cost insertion/deletion/substitution distance between the two sequences.
- R4: `done_o` is high in the cycle after exactly N + Ls + Lt + 2 rising edges following the edge that captured `start_i`. Here Ls and Lt are the effective lengths.
- R5: `done_o` lasts exactly one cycle, and `busy_o` falls on the same edge that raises it. `dist_o` changes only on that edge and holds its value until the next done.
- R6: A `start_i` pulse while `busy_o` is high is ignored: the running comparison finishes with its own operands and latency.
- R7: The reported distance is min(true distance, 2^DW - 1).
- R8: A length above N is treated as N.
- R9: Symbol k of a sequence (k = 1 upward) is bits [2k-1:2k-2] of its input vector. Two symbols are equal only when their 2-bit codes are identical, and equal symbols cost nothing to align.
- R10: When one sequence is empty, the distance is the length of the other sequence, subject to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a comparison when idle |
| src_len_i | input | $clog2(N+1) | Source sequence length |
| tgt_len_i | input | $clog2(N+1) | Target sequence length |
| src_seq_i | input | 2*N | Source symbols, symbol 1 in the low bits |
| tgt_seq_i | input | 2*N | Target symbols, symbol 1 in the low bits |
| busy_o | output | 1 | Comparison in progress |
| done_o | output | 1 | One-cycle strobe marking a new distance |
| dist_o | output | DW | Edit distance, saturating |

## Verification
The bench builds two instances.

The first uses N = 8 with the default DW = 4. Its distances (at most 8) stay below the ceiling of 15, so it checks the exact distance. It also covers every length pair from empty to full, lengths above N that must be clamped, and a start pulse issued mid-run.

The second uses N = 4 with DW = 2. Its ceiling is 3, so a distance of 4 and border values of 4 actually hit saturation. It also runs with a shorter latency, which checks that the timing formula tracks N.

// File: rtl/edc_pkg.sv
// Shared types for the edit distance array.
// Assumes symbols are fixed-width codes; a token is one symbol plus a valid flag.
package edc_pkg;
    localparam int CH_W = 2;

    typedef struct packed {
        logic            vld;
        logic [CH_W-1:0] ch;
    } tok_t;
endpackage

// File: rtl/edc_cell.sv
// One processing cell owning diagonal DIAG (= i - j) of the distance table.
// Passes source tokens downward and target tokens upward, one cell per cycle.
// When both tokens are present it forms a new table entry from its own
// previous value and its two neighbours' values; at step N+|DIAG| it loads
// the border value |DIAG|. Assumes the neighbour values are registered in
// the adjacent cells.
module edc_cell
    import edc_pkg::*;
#(
    parameter int N    = 8,
    parameter int DW   = 4,
    parameter int KW   = 5,
    parameter int DIAG = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [KW-1:0] step,
    input  tok_t          src_in,
    input  tok_t          tgt_in,
    input  logic [DW-1:0] lo_val,
    input  logic [DW-1:0] hi_val,
    output tok_t          src_q,
    output tok_t          tgt_q,
    output logic [DW-1:0] val_q
);
    localparam int            ABS_D = (DIAG < 0) ? -DIAG : DIAG;
    localparam logic [DW-1:0] TOPV  = {DW{1'b1}};
    localparam logic [DW-1:0] BVAL  = (ABS_D >= (2 ** DW) - 1) ? TOPV : DW'(ABS_D);
    localparam logic [KW-1:0] BSTEP = KW'(N + ABS_D);

    logic [DW-1:0] from_lo, from_hi, from_diag, best;

    function automatic logic [DW-1:0] inc_sat(input logic [DW-1:0] x);
        return (x == TOPV) ? x : x + 1'b1;
    endfunction

    // Candidate values from the three neighbouring table entries, then the minimum.
    always_comb begin
        from_lo   = inc_sat(lo_val);
        from_hi   = inc_sat(hi_val);
        from_diag = (src_q.ch != tgt_q.ch) ? inc_sat(val_q) : val_q;
        best      = (from_lo < from_hi) ? from_lo : from_hi;
        if (from_diag < best) begin
            best = from_diag;
        end
    end

    // Token shifting and table-entry update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            src_q <= '0;
            tgt_q <= '0;
            val_q <= '0;
        end else begin
            src_q <= src_in;
            tgt_q <= tgt_in;
            if (step == BSTEP) begin
                val_q <= BVAL;
            end else if (src_q.vld && tgt_q.vld) begin
                val_q <= best;
            end
        end
    end
endmodule

// File: rtl/edc_ctrl.sv
// Sequencer for the edit distance array.
// Captures operands on an accepted start, counts steps, injects one source
// symbol at the top end and one target symbol at the bottom end on every
// even step, and captures the result from the cell on diagonal Ls-Lt once
// the last table entry has been written. Assumes lengths are clamped to N here.
module edc_ctrl
    import edc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 4,
    parameter int LW = 4,
    parameter int KW = 5,
    parameter int IW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LW-1:0]      src_len_i,
    input  logic [LW-1:0]      tgt_len_i,
    input  logic [N*CH_W-1:0]  src_seq_i,
    input  logic [N*CH_W-1:0]  tgt_seq_i,
    input  logic [DW-1:0]      end_val,
    output logic               clr,
    output logic [KW-1:0]      step,
    output tok_t               src_inj,
    output tok_t               tgt_inj,
    output logic [IW-1:0]      end_idx,
    output logic               busy_o,
    output logic               done_o,
    output logic [DW-1:0]      dist_o
);
    logic [LW-1:0]     ls, lt;
    logic [N*CH_W-1:0] sseq, tseq;
    logic [KW-1:0]     k_next;
    int                half;
    logic              last_step;

    function automatic logic [CH_W-1:0] pick(input logic [N*CH_W-1:0] seq, input int idx);
        logic [CH_W-1:0] r;
        r = '0;
        for (int p = 0; p < N; p++) begin
            if (p == idx) begin
                r = seq[p*CH_W +: CH_W];
            end
        end
        return r;
    endfunction

    // Accepted start clears the array.
    assign clr = start_i && !busy_o;

    // Token for the next step at each end of the array, and the end condition.
    always_comb begin
        k_next    = step + 1'b1;
        half      = int'(k_next >> 1);
        src_inj   = '0;
        tgt_inj   = '0;
        if (busy_o && !k_next[0] && half != 0) begin
            if (half <= int'(ls)) begin
                src_inj.vld = 1'b1;
                src_inj.ch  = pick(sseq, half - 1);
            end
            if (half <= int'(lt)) begin
                tgt_inj.vld = 1'b1;
                tgt_inj.ch  = pick(tseq, half - 1);
            end
        end
        last_step = busy_o && (int'(step) == N + int'(ls) + int'(lt) + 1);
        end_idx   = IW'(int'(ls) - int'(lt) + N);
    end

    // Operand capture, step counting and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            dist_o <= '0;
            step   <= '0;
            ls     <= '0;
            lt     <= '0;
            sseq   <= '0;
            tseq   <= '0;
        end else begin
            done_o <= 1'b0;
            if (clr) begin
                busy_o <= 1'b1;
                step   <= '0;
                ls     <= (int'(src_len_i) > N) ? LW'(N) : src_len_i;
                lt     <= (int'(tgt_len_i) > N) ? LW'(N) : tgt_len_i;
                sseq   <= src_seq_i;
                tseq   <= tgt_seq_i;
            end else if (last_step) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
                dist_o <= end_val;
            end else if (busy_o) begin
                step <= k_next;
            end
        end
    end
endmodule

// File: rtl/edit_dist_array.sv
// Top of the systolic edit distance array: 2N+1 cells, one per table
// diagonal, fed from both ends by the sequencer. Source tokens travel
// toward cell 0, target tokens toward cell 2N.
module edit_dist_array
    import edc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [$clog2(N+1)-1:0] src_len_i,
    input  logic [$clog2(N+1)-1:0] tgt_len_i,
    input  logic [2*N-1:0]       src_seq_i,
    input  logic [2*N-1:0]       tgt_seq_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DW-1:0]        dist_o
);
    localparam int            NC   = 2 * N + 1;
    localparam int            LW   = $clog2(N + 1);
    localparam int            KW   = $clog2(3 * N + 2);
    localparam int            IW   = $clog2(NC);
    localparam logic [DW-1:0] TOPV = {DW{1'b1}};

    logic          clr;
    logic [KW-1:0] step;
    tok_t          src_inj, tgt_inj;
    logic [IW-1:0] end_idx;
    logic [DW-1:0] end_val;

    tok_t          src_q [NC];
    tok_t          tgt_q [NC];
    logic [DW-1:0] val_q [NC];

    edc_ctrl #(.N(N), .DW(DW), .LW(LW), .KW(KW), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .src_len_i (src_len_i),
        .tgt_len_i (tgt_len_i),
        .src_seq_i (src_seq_i),
        .tgt_seq_i (tgt_seq_i),
        .end_val   (end_val),
        .clr       (clr),
        .step      (step),
        .src_inj   (src_inj),
        .tgt_inj   (tgt_inj),
        .end_idx   (end_idx),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .dist_o    (dist_o)
    );

    // Result tap on the diagonal where the final entry lands.
    assign end_val = val_q[end_idx];

    for (genvar c = 0; c < NC; c++) begin : g_cell
        tok_t          s_in, t_in;
        logic [DW-1:0] lo_v, hi_v;

        if (c == NC - 1) begin : g_top
            assign s_in = src_inj;
            assign hi_v = TOPV;
        end else begin : g_mid_hi
            assign s_in = src_q[c+1];
            assign hi_v = val_q[c+1];
        end

        if (c == 0) begin : g_bot
            assign t_in = tgt_inj;
            assign lo_v = TOPV;
        end else begin : g_mid_lo
            assign t_in = tgt_q[c-1];
            assign lo_v = val_q[c-1];
        end

        edc_cell #(.N(N), .DW(DW), .KW(KW), .DIAG(c - N)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .step   (step),
            .src_in (s_in),
            .tgt_in (t_in),
            .lo_val (lo_v),
            .hi_val (hi_v),
            .src_q  (src_q[c]),
            .tgt_q  (tgt_q[c]),
            .val_q  (val_q[c])
        );
    end
endmodule

// File: rtl/edit_dist_array_chk.sv
// Port-level protocol checks for the edit distance array, bound to the top.
module edit_dist_array_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] dist_o
);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_dist_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(dist_o));

    assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));
endmodule

bind edit_dist_array edit_dist_array_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .dist_o  (dist_o)
);

// File: tb/edit_dist_array_tb.sv
`timescale 1ns/1ps
module edit_dist_array_tb;
    localparam int NA = 8;
    localparam int NB = 4;
    localparam int DB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_start = 0, b_start = 0;
    logic [3:0]  a_sl = 0, a_tl = 0;
    logic [2:0]  b_sl = 0, b_tl = 0;
    logic [15:0] a_ss = 0, a_ts = 0;
    logic [7:0]  b_ss = 0, b_ts = 0;
    logic        a_busy, a_done, b_busy, b_done;
    logic [3:0]  a_dist;
    logic [1:0]  b_dist;

    int n_checks = 0;
    int n_fail   = 0;

    edit_dist_array #(.N(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(a_start), .src_len_i(a_sl), .tgt_len_i(a_tl),
        .src_seq_i(a_ss), .tgt_seq_i(a_ts), .busy_o(a_busy), .done_o(a_done), .dist_o(a_dist));

    edit_dist_array #(.N(NB), .DW(DB)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .start_i(b_start), .src_len_i(b_sl), .tgt_len_i(b_tl),
        .src_seq_i(b_ss), .tgt_seq_i(b_ts), .busy_o(b_busy), .done_o(b_done), .dist_o(b_dist));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Unit-cost edit distance over symbols at bits [2k-1:2k-2].
    function automatic int lev(input logic [15:0] s, input logic [15:0] t, input int ls, input int lt);
        int d [0:8][0:8];
        for (int i = 0; i <= ls; i++) d[i][0] = i;
        for (int j = 0; j <= lt; j++) d[0][j] = j;
        for (int i = 1; i <= ls; i++) begin
            for (int j = 1; j <= lt; j++) begin
                int m;
                m = d[i-1][j-1] + ((s[2*(i-1) +: 2] != t[2*(j-1) +: 2]) ? 1 : 0);
                if (d[i-1][j] + 1 < m) m = d[i-1][j] + 1;
                if (d[i][j-1] + 1 < m) m = d[i][j-1] + 1;
                d[i][j] = m;
            end
        end
        return d[ls][lt];
    endfunction

    // One comparison on either instance; optional mid-run start pulse.
    task automatic run_case(input bit use_b, input int ls, input int lt,
                            input logic [15:0] s, input logic [15:0] t,
                            input bit disturb, input string req);
        int n, cap, lse, lte, exp, cyc, got, held;
        n   = use_b ? NB : NA;
        cap = use_b ? 3 : 15;
        lse = (ls > n) ? n : ls;
        lte = (lt > n) ? n : lt;
        exp = lev(s, t, lse, lte);
        if (exp > cap) exp = cap;
        @(negedge clk);
        if (use_b) begin
            b_start = 1; b_sl = ls[2:0]; b_tl = lt[2:0]; b_ss = s[7:0]; b_ts = t[7:0];
        end else begin
            a_start = 1; a_sl = ls[3:0]; a_tl = lt[3:0]; a_ss = s; a_ts = t;
        end
        @(negedge clk);
        a_start = 0; b_start = 0;
        cyc = 0;
        while (!(use_b ? b_done : a_done) && cyc < 300) begin
            if (disturb && cyc == 3) begin
                // R6: a competing request with different operands
                if (use_b) begin b_start = 1; b_sl = 0; b_tl = 3'(NB); b_ss = ~s[7:0]; end
                else begin a_start = 1; a_sl = 0; a_tl = 4'(NA); a_ss = ~s; end
            end else begin
                a_start = 0; b_start = 0;
            end
            @(negedge clk);
            cyc++;
        end
        a_start = 0; b_start = 0;
        got = use_b ? int'(b_dist) : int'(a_dist);
        check(got == exp, req, got, exp);
        check(cyc == n + lse + lte + 2, "R4 latency", cyc, n + lse + lte + 2);
        held = got;
        @(negedge clk);
        got = use_b ? int'(b_dist) : int'(a_dist);
        check(!(use_b ? b_done : a_done) && got == held, "R5 done pulse and held dist", got, held);
    endtask

    initial begin
        #(190000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(!a_busy && !a_done && a_dist == 0, "R1 reset state A", int'(a_dist), 0);
        check(!b_busy && !b_done && b_dist == 0, "R1 reset state B", int'(b_dist), 0);
        rst_n = 1;
        @(negedge clk);
        check(!a_busy && !a_done && a_dist == 0, "R1 after release", int'(a_busy), 0);

        // R2: launch is visible the cycle after start
        @(negedge clk); a_start = 1; a_sl = 2; a_tl = 2; a_ss = 16'h0005; a_ts = 16'h0004;
        @(negedge clk); a_start = 0;
        check(a_busy == 1'b1, "R2 busy after start", int'(a_busy), 1);
        while (!a_done) @(negedge clk);
        check(a_dist == 1, "R3 two-symbol substitution", int'(a_dist), 1);

        // Directed cases, wide instance
        run_case(0, 0, 0, 16'h0, 16'h0, 0, "R10 both empty");
        run_case(0, 0, 5, 16'h0, 16'h1234, 0, "R10 empty source");
        run_case(0, 6, 0, 16'h0abc, 16'h0, 0, "R10 empty target");
        run_case(0, 8, 8, 16'h9c3e, 16'h9c3e, 0, "R9 identical sequences");
        run_case(0, 8, 8, 16'h0000, 16'h5555, 0, "R9 all codes differ");
        run_case(0, 8, 8, 16'h4444, 16'h1111, 0, "R3 shifted pattern");
        run_case(0, 1, 1, 16'h0002, 16'h0002, 0, "R9 single equal symbol");
        run_case(0, 1, 1, 16'h0003, 16'h0001, 0, "R9 single different symbol");
        run_case(0, 12, 15, 16'h7e21, 16'h7e21, 0, "R8 lengths clamped to N");
        run_case(0, 12, 3, 16'hffff, 16'h003f, 0, "R8 one length clamped");
        run_case(0, 5, 7, 16'h02d3, 16'h1b6c, 1, "R6 start ignored while busy");

        // Directed cases, saturating instance
        run_case(1, 4, 0, 16'h0, 16'h0, 0, "R7 border value saturates");
        run_case(1, 4, 4, 16'h0000, 16'h00ff, 0, "R7 distance saturates");
        run_case(1, 4, 4, 16'h00b4, 16'h00b4, 0, "R3 identical small");
        run_case(1, 6, 2, 16'h00e4, 16'h0004, 0, "R8 clamp small");
        run_case(1, 3, 2, 16'h0021, 16'h0009, 1, "R6 start ignored small");

        // Constrained random
        for (int r = 0; r < 40; r++) begin
            int ls, lt;
            logic [15:0] s, t, msk;
            ls  = $urandom_range(0, NA);
            lt  = $urandom_range(0, NA);
            msk = (r % 3 == 0) ? 16'h5555 : 16'hffff;
            s   = 16'($urandom) & msk;
            t   = 16'($urandom) & msk;
            if (r % 5 == 1) t = s ^ (16'h3 << (2 * $urandom_range(0, 7)));
            run_case(0, ls, lt, s, t, 0, "R3 random");
        end
        for (int r = 0; r < 25; r++) begin
            int ls, lt;
            logic [15:0] s, t;
            ls = $urandom_range(0, NB);
            lt = $urandom_range(0, NB);
            s  = 16'($urandom) & 16'h00ff;
            t  = 16'($urandom) & 16'h00ff;
            run_case(1, ls, lt, s, t, 0, "R7 random saturating");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule